// File: doc/BRIEF.md
# Serial Flash Power-Down Gate

This block sits at the SPI-slave edge of a serial NOR flash model and owns only the power-mode decision. It samples the chip-select, serial clock and data pins into the system clock domain. It shifts in instruction bytes MSB first on each rising serial clock edge while chip select is low. It tracks three power states: standby, entering power-down and deep power-down.

An instruction other than power-down or wake is handed to downstream logic as a one-cycle strobe with its opcode, but only while the part is in standby. The power-down instruction is acted on only at the chip-select rise that closes a frame of exactly one byte, and only while the internal program or erase engine is idle. The engine is represented here by a busy input. A parameterised delay then runs before the low-current indication comes on. The wake instruction is the only way back to standby.

Top module: `spi_flash_pwr_gate`

## Requirements
- R1: After reset the block is in standby: `pd_mode_o`, `low_pwr_o` and `op_valid_o` are all 0.
- R2: In standby, a frame whose first byte is neither 0xB9 nor 0xAB produces exactly one `op_valid_o` pulse, with `op_code_o` equal to that byte, once its eighth bit has been latched. Bytes are shifted MSB first on rising SCK while chip select is low. Later bytes of the same frame are not forwarded.
- R3: The power-down opcode 0xB9 takes effect only if chip select rises with exactly 8 bits latched. A frame of 7 or 9 bits leaves the state unchanged.
- R4: A power-down frame that closes while `core_busy_i` is high is rejected, and the block stays in standby.
- R5: After an accepted power-down, `pd_mode_o` goes to 1 and `low_pwr_o` stays 0 for exactly `T_DP_CYC` clock cycles, then goes to 1.
- R6: While `pd_mode_o` is 1, no opcode is forwarded on `op_valid_o`, and a further power-down frame has no effect.
- R7: The wake opcode 0xAB returns the block to standby (both flags 0) when chip select rises after a nonzero multiple of 8 bits. A wake frame of any other length is ignored. Wake is honoured both during the entry delay and in deep power-down.
- R8: Opcodes 0xB9 and 0xAB never appear on `op_valid_o`. A wake frame in standby changes nothing.
- R9: The bit count restarts at every chip-select fall, so an aborted frame of a few bits does not disturb the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| spi_sck_i | input | 1 | Serial clock pin, asynchronous |
| spi_cs_n_i | input | 1 | Chip select pin, active low, asynchronous |
| spi_mosi_i | input | 1 | Serial data in pin, asynchronous |
| core_busy_i | input | 1 | High while a program, erase or write cycle runs |
| pd_mode_o | output | 1 | 1 while entering or in deep power-down |
| low_pwr_o | output | 1 | 1 once the low-current state is reached |
| op_valid_o | output | 1 | One-cycle strobe for a forwarded opcode |
| op_code_o | output | 8 | Opcode that goes with `op_valid_o` |

## Verification
The assertions assume that the pins change slowly enough for the synchronisers to see every serial clock level. They also assume that chip select never moves in the same system cycle as a serial clock edge, so a frame edge and a bit edge are never merged. The stimulus holds each serial clock phase and each chip-select setup for several system cycles, and it changes data only while the serial clock is low. The busy input is changed only while chip select is high, so its value is settled at every frame close.

// File: rtl/spi_pd_pkg.sv
package spi_pd_pkg;

    localparam logic [7:0] OPC_PWR_DOWN = 8'hB9;
    localparam logic [7:0] OPC_WAKE     = 8'hAB;

    typedef enum logic [1:0] {
        PS_STANDBY  = 2'd0,
        PS_ENTERING = 2'd1,
        PS_DEEP     = 2'd2
    } pwr_state_e;

    // opcode completed (eighth bit of a frame latched)
    typedef struct packed {
        logic       valid;
        logic [7:0] opcode;
    } opc_evt_t;

    // frame closed by chip-select rise
    typedef struct packed {
        logic       valid;
        logic       exact_byte;
        logic       whole_bytes;
        logic [7:0] opcode;
    } frame_end_t;

    function automatic logic is_local_op(input logic [7:0] op);
        return (op == OPC_PWR_DOWN) || (op == OPC_WAKE);
    endfunction

endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[0] <= RST_VAL;
                else     stage_q[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RST_VAL;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pd_frame.sv
module pd_frame
    import spi_pd_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck_s,
    input  logic       cs_n_s,
    input  logic       mosi_s,
    output opc_evt_t   opc_o,
    output frame_end_t fend_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE_BYTE = CNT_W'(8);
    localparam logic [CNT_W-1:0] CNT_LAST_BIT = CNT_W'(7);

    logic             sck_d, cs_d;
    logic             sck_rise, cs_fall, cs_rise;
    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       shift_q;
    logic [7:0]       first_q;
    opc_evt_t         opc_q;
    frame_end_t       fend_q;

    assign sck_rise = sck_s & ~sck_d;
    assign cs_fall  = ~cs_n_s & cs_d;
    assign cs_rise  = cs_n_s & ~cs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d   <= 1'b0;
            cs_d    <= 1'b1;
            cnt_q   <= '0;
            shift_q <= '0;
            first_q <= '0;
            opc_q   <= '0;
            fend_q  <= '0;
        end else begin
            sck_d        <= sck_s;
            cs_d         <= cs_n_s;
            opc_q.valid  <= 1'b0;
            fend_q.valid <= 1'b0;
            if (cs_fall) begin
                cnt_q   <= '0;
                shift_q <= '0;
                first_q <= '0;
            end else if (cs_rise) begin
                fend_q.valid       <= 1'b1;
                fend_q.opcode      <= first_q;
                fend_q.exact_byte  <= (cnt_q == CNT_ONE_BYTE);
                fend_q.whole_bytes <= (cnt_q != '0) && (cnt_q[2:0] == 3'd0)
                                      && (cnt_q != CNT_MAX);
            end else if (sck_rise && !cs_n_s) begin
                shift_q <= {shift_q[6:0], mosi_s};
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_LAST_BIT) begin
                    first_q      <= {shift_q[6:0], mosi_s};
                    opc_q.valid  <= 1'b1;
                    opc_q.opcode <= {shift_q[6:0], mosi_s};
                end
            end
        end
    end

    assign opc_o  = opc_q;
    assign fend_o = fend_q;

    // R9: a chip-select fall always restarts the count
    p_cnt_restart_r9: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> (cnt_q == '0));

    // R2: at most one opcode event per frame, never back to back
    p_opc_single_r2: assert property (@(posedge clk) disable iff (rst)
        opc_q.valid |=> !opc_q.valid);

endmodule

// File: rtl/pd_ctrl.sv
module pd_ctrl
    import spi_pd_pkg::*;
#(
    parameter int T_DP_CYC = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  opc_evt_t   opc_i,
    input  frame_end_t fend_i,
    input  logic       busy_i,
    output logic       pd_mode_o,
    output logic       low_pwr_o,
    output logic       op_valid_o,
    output logic [7:0] op_code_o
);

    localparam int DLY_W = $clog2(T_DP_CYC + 1);
    localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(T_DP_CYC - 1);

    pwr_state_e       state_q;
    logic [DLY_W-1:0] dly_q;
    logic             op_valid_q;
    logic [7:0]       op_code_q;
    logic             wake_req, sleep_req;

    assign wake_req  = fend_i.valid && fend_i.whole_bytes && (fend_i.opcode == OPC_WAKE);
    assign sleep_req = fend_i.valid && fend_i.exact_byte && (fend_i.opcode == OPC_PWR_DOWN)
                       && !busy_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= PS_STANDBY;
            dly_q      <= '0;
            op_valid_q <= 1'b0;
            op_code_q  <= '0;
        end else begin
            op_valid_q <= 1'b0;
            if (opc_i.valid && state_q == PS_STANDBY && !is_local_op(opc_i.opcode)) begin
                op_valid_q <= 1'b1;
                op_code_q  <= opc_i.opcode;
            end
            case (state_q)
                PS_STANDBY: begin
                    if (sleep_req) begin
                        state_q <= PS_ENTERING;
                        dly_q   <= DLY_LOAD;
                    end
                end
                PS_ENTERING: begin
                    if (wake_req)          state_q <= PS_STANDBY;
                    else if (dly_q == '0)  state_q <= PS_DEEP;
                    else                   dly_q   <= dly_q - 1'b1;
                end
                PS_DEEP: begin
                    if (wake_req) state_q <= PS_STANDBY;
                end
                default: state_q <= PS_STANDBY;
            endcase
        end
    end

    assign pd_mode_o  = (state_q != PS_STANDBY);
    assign low_pwr_o  = (state_q == PS_DEEP);
    assign op_valid_o = op_valid_q;
    assign op_code_o  = op_code_q;

    // R4: no departure from standby while the core is busy
    p_busy_blocks_dp_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_STANDBY && busy_i) |=> (state_q == PS_STANDBY));

    // R6: a forwarded opcode only follows a standby cycle
    p_fwd_only_standby_r6: assert property (@(posedge clk) disable iff (rst)
        op_valid_q |-> $past(state_q == PS_STANDBY));

    // R5: low-current state is reached only through the entry delay
    p_deep_via_entry_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == PS_DEEP) |-> $past(state_q == PS_ENTERING));

    // R7: deep power-down is left only on a valid wake frame
    p_wake_only_exit_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_DEEP && !wake_req) |=> (state_q == PS_DEEP));

    // R8: local opcodes never leave the block
    p_no_local_fwd_r8: assert property (@(posedge clk) disable iff (rst)
        op_valid_q |-> !is_local_op(op_code_q));

endmodule

// File: rtl/spi_flash_pwr_gate.sv
module spi_flash_pwr_gate
    import spi_pd_pkg::*;
#(
    parameter int T_DP_CYC    = 24,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_sck_i,
    input  logic       spi_cs_n_i,
    input  logic       spi_mosi_i,
    input  logic       core_busy_i,
    output logic       pd_mode_o,
    output logic       low_pwr_o,
    output logic       op_valid_o,
    output logic [7:0] op_code_o
);

    logic [2:0] pins_s;
    opc_evt_t   opc;
    frame_end_t fend;

    // bit order: {sck, cs_n, mosi}; chip select idles high
    pd_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({spi_sck_i, spi_cs_n_i, spi_mosi_i}),
        .q_o (pins_s)
    );

    pd_frame #(
        .CNT_W (CNT_W)
    ) u_frame (
        .clk    (clk),
        .rst    (rst),
        .sck_s  (pins_s[2]),
        .cs_n_s (pins_s[1]),
        .mosi_s (pins_s[0]),
        .opc_o  (opc),
        .fend_o (fend)
    );

    pd_ctrl #(
        .T_DP_CYC (T_DP_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .opc_i      (opc),
        .fend_i     (fend),
        .busy_i     (core_busy_i),
        .pd_mode_o  (pd_mode_o),
        .low_pwr_o  (low_pwr_o),
        .op_valid_o (op_valid_o),
        .op_code_o  (op_code_o)
    );

endmodule

// File: tb/spi_flash_pwr_gate_tb.sv
module spi_flash_pwr_gate_tb_top;

    localparam int T_DP = 24;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       busy = 1'b0;
    logic       pd_mode, low_pwr, op_valid;
    logic [7:0] op_code;

    int         n_vec = 0;
    int         n_bad = 0;
    int         fwd_cnt = 0;
    logic [7:0] fwd_last = 8'h00;
    logic       done = 1'b0;

    always #4 clk = ~clk;

    spi_flash_pwr_gate #(.T_DP_CYC(T_DP)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .spi_sck_i   (sck),
        .spi_cs_n_i  (cs_n),
        .spi_mosi_i  (mosi),
        .core_busy_i (busy),
        .pd_mode_o   (pd_mode),
        .low_pwr_o   (low_pwr),
        .op_valid_o  (op_valid),
        .op_code_o   (op_code)
    );

    always @(negedge clk) begin
        if (!rst && op_valid) begin
            fwd_cnt  <= fwd_cnt + 1;
            fwd_last <= op_code;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [31:0] data, input int nbits);
        cs_n = 1'b0;
        idle(HALF);
        for (int i = nbits - 1; i >= 0; i--) begin
            mosi = data[i];
            idle(HALF);
            sck = 1'b1;
            idle(HALF);
            sck = 1'b0;
        end
        idle(HALF);
        cs_n = 1'b1;
        idle(10);
    endtask

    task automatic t_reset;
        check("R1 pd_mode", int'(pd_mode), 0);
        check("R1 low_pwr", int'(low_pwr), 0);
        check("R1 op_valid", int'(op_valid), 0);
    endtask

    task automatic t_forward;
        int base;
        base = fwd_cnt;
        send_frame(32'h06, 8);
        check("R2 count", fwd_cnt - base, 1);
        check("R2 code", int'(fwd_last), 'h06);
        base = fwd_cnt;
        send_frame(32'h03_12_34, 24);
        check("R2 multi-byte count", fwd_cnt - base, 1);
        check("R2 multi-byte code", int'(fwd_last), 'h03);
    endtask

    task automatic t_bad_length;
        send_frame(32'h5C, 7);
        check("R3 seven bits", int'(pd_mode), 0);
        send_frame(32'h172, 9);
        check("R3 nine bits", int'(pd_mode), 0);
    endtask

    task automatic t_busy;
        busy = 1'b1;
        idle(4);
        send_frame(32'hB9, 8);
        idle(T_DP + 4);
        check("R4 busy pd_mode", int'(pd_mode), 0);
        check("R4 busy low_pwr", int'(low_pwr), 0);
        busy = 1'b0;
        idle(4);
    endtask

    task automatic t_local_standby;
        int base;
        base = fwd_cnt;
        send_frame(32'hAB, 8);
        check("R8 wake in standby", int'(pd_mode), 0);
        check("R8 no forward", fwd_cnt - base, 0);
    endtask

    task automatic t_enter;
        int k;
        int base;
        base = fwd_cnt;
        send_frame(32'h7, 3);
        cs_n = 1'b0;
        idle(HALF);
        for (int i = 7; i >= 0; i--) begin
            mosi = 8'hB9 >> i;
            idle(HALF);
            sck = 1'b1;
            idle(HALF);
            sck = 1'b0;
        end
        idle(HALF);
        cs_n = 1'b1;
        k = 0;
        while (!pd_mode && k < 50) begin
            idle(1);
            k++;
        end
        check("R9 entry after aborted frame", int'(pd_mode), 1);
        check("R5 low_pwr during delay", int'(low_pwr), 0);
        check("R8 no forward of 0xB9", fwd_cnt - base, 0);
        k = 0;
        while (!low_pwr && k < T_DP + 20) begin
            idle(1);
            k++;
        end
        check("R5 delay cycles", k, T_DP);
    endtask

    task automatic t_blocked;
        int base;
        base = fwd_cnt;
        send_frame(32'h06, 8);
        send_frame(32'h02, 8);
        send_frame(32'hB9, 8);
        check("R6 no forward in deep", fwd_cnt - base, 0);
        check("R6 still low_pwr", int'(low_pwr), 1);
    endtask

    task automatic t_wake;
        int base;
        send_frame(32'hAB5, 12);
        check("R7 twelve-bit wake ignored", int'(low_pwr), 1);
        send_frame(32'hAB00, 16);
        check("R7 wake pd_mode", int'(pd_mode), 0);
        check("R7 wake low_pwr", int'(low_pwr), 0);
        base = fwd_cnt;
        send_frame(32'h05, 8);
        check("R2 forward after wake", fwd_cnt - base, 1);
    endtask

    task automatic t_wake_entering;
        send_frame(32'hB9, 8);
        check("R7 entering pd_mode", int'(pd_mode), 1);
        send_frame(32'hAB, 8);
        check("R7 wake during delay", int'(pd_mode), 0);
        idle(T_DP + 4);
        check("R7 stays standby", int'(low_pwr), 0);
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        idle(5);
        rst = 1'b0;
        idle(6);
        t_reset();
        t_forward();
        t_bad_length();
        t_busy();
        t_local_standby();
        t_enter();
        t_blocked();
        t_wake();
        t_wake_entering();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule